// File: doc/BRIEF.md
# Streaming Payload XOR Scrambler

This block sits inline in a 64-bit packet pipeline and obscures the IPv4 payload of every frame by XORing it with a 32-bit key. The Ethernet and IPv4 headers leave the block untouched, so later stages can still route the frame. XOR is its own inverse, so the same block, loaded with the same key, turns scrambled frames back into the originals.

Each packet starts with one or more pipeline metadata words, which carry a nonzero control field. These words are forwarded verbatim and are not counted as frame bytes. The first word with a zero control field is frame word 0. Frame byte 1 sits in bits 63:56 of that word, and later bytes follow toward the least significant end. The 34 header bytes end two bytes into frame word 4. In that word the two upper bytes pass through and the six lower bytes are XORed. A nonzero control value on a frame word marks that word as the last of the packet. Incoming words wait in a small fall-through FIFO. The output is registered.

Top module: `pkt_xor_cipher`

## Requirements
- R1: Sending a frame already scrambled with key K through the block with key K yields the original frame, byte for byte.
- R2: Frame bytes 1 to 34 leave the block unchanged. These are frame words 0 to 3 and bits 63:48 of frame word 4.
- R3: Every frame byte from 35 up to and including the last word is XORed with the matching byte of `{key,key}`. Bits 47:0 of word 4 and all bits of word 5 and later are affected.
- R4: Words with a nonzero `in_ctrl` that arrive before the first zero-control word of a packet are forwarded with data unchanged and do not advance the frame byte count.
- R5: A frame word with a nonzero `in_ctrl` ends the packet, at any frame position from word 1 onward. `out_ctrl` always equals the input control of the same word. The word after an end-of-packet word is treated as metadata or as a new frame word 0.
- R6: `out_wr` is high only in a cycle whose preceding clock edge sampled `out_rdy` high. Words leave the block in arrival order, each exactly once.
- R7: `in_rdy` is low exactly while the FIFO holds `FIFO_DEPTH` words. With `out_rdy` held low, the block takes in no more than `FIFO_DEPTH` words.
- R8: A key written while a frame is in flight does not affect that frame. It applies from the next frame on.
- R9: After synchronous reset the FIFO is empty (`in_rdy` high), `out_wr` is low and the key is zero, so frames pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_data | input | 64 | Upstream data word |
| in_ctrl | input | 8 | Upstream control: metadata tag or end-of-packet byte-valid marker |
| in_wr | input | 1 | Upstream write strobe |
| in_rdy | output | 1 | FIFO has room for a word |
| out_data | output | 64 | Downstream data word |
| out_ctrl | output | 8 | Downstream control, equal to the input control of the word |
| out_wr | output | 1 | Downstream write strobe |
| out_rdy | input | 1 | Downstream can take a word in the next cycle |
| key_wr | input | 1 | Key register write enable |
| key_wdata | input | 32 | Value written to the key register |

## Verification
If the frame word counter or state machine drifts, the scrambling boundary shifts. The first symptom is a wrong byte in frame word 4 or a scrambled header word, and it shows on the output one cycle after that word is popped. A missed end-of-packet leaves the next packet's metadata scrambled. An early key load shows as a mid-frame change of the XOR pattern. The scoreboard compares every output word against a byte-position model, so each such fault appears on the first word it touches.

// File: rtl/xorc_pkg.sv
package xorc_pkg;
  typedef enum logic [1:0] {
    ST_META = 2'd0,
    ST_HEAD = 2'd1,
    ST_EDGE = 2'd2,
    ST_BODY = 2'd3
  } xorc_state_e;
endpackage

// File: rtl/xorc_fifo.sv
module xorc_fifo #(
  parameter int W     = 72,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] count;
  logic          do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (do_push) wptr <= (wptr == AW'(DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == AW'(DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // A write offered while full and not draining must not change occupancy.
  assert_full_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop) |=> (count == $past(count)));
endmodule

// File: rtl/xorc_key.sv
module xorc_key #(
  parameter int KEY_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [KEY_W-1:0] wdata,
  input  logic             load,
  output logic [KEY_W-1:0] key_act
);
  logic [KEY_W-1:0] key_sw;

  always_ff @(posedge clk) begin
    if (rst) begin
      key_sw  <= '0;
      key_act <= '0;
    end else begin
      if (wr)   key_sw  <= wdata;
      if (load) key_act <= key_sw;
    end
  end
endmodule

// File: rtl/xorc_framer.sv
module xorc_framer
  import xorc_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int CTRL_W    = 8,
  parameter int KEY_W     = 32,
  parameter int HDR_BYTES = 34
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [KEY_W-1:0]  key,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CTRL_W-1:0] in_ctrl,
  input  logic              out_rdy,
  output logic              pop,
  output logic [DATA_W-1:0] out_data,
  output logic [CTRL_W-1:0] out_ctrl,
  output logic              out_wr,
  output logic              idle
);
  localparam int BYTES      = DATA_W / 8;
  localparam int REP        = DATA_W / KEY_W;
  localparam int FULL_WORDS = HDR_BYTES / BYTES;
  localparam int PART_BYTES = HDR_BYTES % BYTES;
  localparam int CNT_W      = $clog2(FULL_WORDS + 1);

  xorc_state_e       st;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] key_word, edge_mask, mask;
  logic              is_ctrl;

  assign key_word = {REP{key}};
  assign is_ctrl  = (in_ctrl != '0);
  assign pop      = in_valid && out_rdy;
  assign idle     = (st == ST_META);

  // Boundary word: the leading PART_BYTES bytes belong to the header.
  for (genvar b = 0; b < BYTES; b++) begin : g_edge
    localparam bit IN_HDR = (b < PART_BYTES);
    assign edge_mask[DATA_W-1-8*b -: 8] = IN_HDR ? 8'h00 : 8'hFF;
  end

  always_comb begin
    case (st)
      ST_EDGE: mask = edge_mask;
      ST_BODY: mask = '1;
      default: mask = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_META;
      cnt <= '0;
    end else if (pop) begin
      case (st)
        ST_META: begin
          if (!is_ctrl) begin
            cnt <= CNT_W'(1);
            st  <= (FULL_WORDS <= 1) ? ST_EDGE : ST_HEAD;
          end
        end
        ST_HEAD: begin
          if (is_ctrl)                              st <= ST_META;
          else if (cnt == CNT_W'(FULL_WORDS - 1))   st <= ST_EDGE;
          else                                      cnt <= cnt + 1'b1;
        end
        ST_EDGE: st <= is_ctrl ? ST_META : ST_BODY;
        default: if (is_ctrl) st <= ST_META;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_wr   <= 1'b0;
      out_data <= '0;
      out_ctrl <= '0;
    end else begin
      out_wr <= pop;
      if (pop) begin
        out_data <= in_data ^ (key_word & mask);
        out_ctrl <= in_ctrl;
      end
    end
  end

  assert_meta_passthru_R4: assert property (@(posedge clk) disable iff (rst)
    (pop && st == ST_META && is_ctrl) |=> (out_wr && out_data == $past(in_data)));
  assert_hdr_clear_R2: assert property (@(posedge clk) disable iff (rst)
    (pop && st == ST_HEAD) |=> (out_data == $past(in_data)));
  assert_ctrl_fwd_R5: assert property (@(posedge clk) disable iff (rst)
    pop |=> (out_ctrl == $past(in_ctrl)));
  assert_eop_return_R5: assert property (@(posedge clk) disable iff (rst)
    (pop && st != ST_META && is_ctrl) |=> (st == ST_META));
endmodule

// File: rtl/pkt_xor_cipher.sv
module pkt_xor_cipher #(
  parameter int DATA_W     = 64,
  parameter int CTRL_W     = 8,
  parameter int KEY_W      = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int HDR_BYTES  = 34
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] in_data,
  input  logic [CTRL_W-1:0] in_ctrl,
  input  logic              in_wr,
  output logic              in_rdy,
  output logic [DATA_W-1:0] out_data,
  output logic [CTRL_W-1:0] out_ctrl,
  output logic              out_wr,
  input  logic              out_rdy,
  input  logic              key_wr,
  input  logic [KEY_W-1:0]  key_wdata
);
  localparam int ITEM_W = DATA_W + CTRL_W;

  logic [ITEM_W-1:0] fifo_dout;
  logic              fifo_empty, fifo_full, fr_pop, fr_idle;
  logic [KEY_W-1:0]  key_act;

  assign in_rdy = !fifo_full;

  xorc_fifo #(.W(ITEM_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (in_wr),
    .din   ({in_ctrl, in_data}),
    .pop   (fr_pop),
    .dout  (fifo_dout),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  xorc_key #(.KEY_W(KEY_W)) u_key (
    .clk     (clk),
    .rst     (rst),
    .wr      (key_wr),
    .wdata   (key_wdata),
    .load    (fr_idle),
    .key_act (key_act)
  );

  xorc_framer #(
    .DATA_W(DATA_W), .CTRL_W(CTRL_W), .KEY_W(KEY_W), .HDR_BYTES(HDR_BYTES)
  ) u_framer (
    .clk      (clk),
    .rst      (rst),
    .key      (key_act),
    .in_valid (!fifo_empty),
    .in_data  (fifo_dout[DATA_W-1:0]),
    .in_ctrl  (fifo_dout[ITEM_W-1:DATA_W]),
    .out_rdy  (out_rdy),
    .pop      (fr_pop),
    .out_data (out_data),
    .out_ctrl (out_ctrl),
    .out_wr   (out_wr),
    .idle     (fr_idle)
  );

  assert_wr_gated_R6: assert property (@(posedge clk) disable iff (rst)
    out_wr |-> $past(out_rdy));
  assert_key_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    !fr_idle |=> $stable(key_act));
endmodule

// File: tb/sim_pkt_xor_cipher.sv
`timescale 1ns/1ps
module sim_pkt_xor_cipher;
  typedef struct packed { logic [7:0] c; logic [63:0] d; } item_t;

  logic        clk = 1'b0, rst = 1'b1;
  logic [63:0] in_data = '0;
  logic [7:0]  in_ctrl = '0;
  logic        in_wr = 1'b0, in_rdy;
  logic [63:0] out_data;
  logic [7:0]  out_ctrl;
  logic        out_wr, out_rdy = 1'b1;
  logic        key_wr = 1'b0;
  logic [31:0] key_wdata = '0;

  item_t stim_q[$];
  item_t exp_q[$];
  int    n_cmp = 0, n_bad = 0;
  string cur_req = "R9";
  bit    bp_en = 0, hold_off = 0, done = 0;
  logic [15:0] lf = 16'hACE1;

  always #2 clk = ~clk;

  pkt_xor_cipher u0 (
    .clk(clk), .rst(rst), .in_data(in_data), .in_ctrl(in_ctrl), .in_wr(in_wr),
    .in_rdy(in_rdy), .out_data(out_data), .out_ctrl(out_ctrl), .out_wr(out_wr),
    .out_rdy(out_rdy), .key_wr(key_wr), .key_wdata(key_wdata)
  );

  // Byte-position model: frame byte n = w*8 + j + 1, byte j=0 at bits 63:56.
  function automatic logic [63:0] scramble(input logic [63:0] d, input int w,
                                           input logic [31:0] k);
    logic [63:0] kk = {k, k};
    for (int j = 0; j < 8; j++)
      if (w * 8 + j + 1 >= 35) d[63-8*j -: 8] = d[63-8*j -: 8] ^ kk[63-8*j -: 8];
    return d;
  endfunction

  task automatic add_packet(input int n_meta, input int n_words, input logic [31:0] k,
                            input logic [7:0] seed, input bit decrypt);
    for (int m = 0; m < n_meta; m++) begin
      item_t it;
      it.c = 8'hF0 | 8'(m + 1);
      it.d = {seed, 8'(m), 48'h00C0_FFEE_0000} ^ 64'h0F0F;
      stim_q.push_back(it);
      exp_q.push_back(it);
    end
    for (int w = 0; w < n_words; w++) begin
      item_t pl, ci;
      pl.c = (w == n_words - 1) ? 8'h04 : 8'h00;
      pl.d = {seed, 8'(w), 16'hA55A, 8'(w * 3), seed ^ 8'h3C, 16'h1234};
      ci.c = pl.c;
      ci.d = scramble(pl.d, w, k);
      if (decrypt) begin stim_q.push_back(ci); exp_q.push_back(pl); end
      else         begin stim_q.push_back(pl); exp_q.push_back(ci); end
    end
  endtask

  task automatic key_write(input logic [31:0] k);
    @(negedge clk); key_wr = 1'b1; key_wdata = k;
    @(negedge clk); key_wr = 1'b0;
  endtask

  task automatic drain();
    while (stim_q.size() != 0 || exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [71:0] got, input logic [71:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, got, exp);
    end
  endtask

  // Driver side: input feed and downstream ready, both from the bench LFSR.
  initial begin
    forever begin
      @(negedge clk);
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      out_rdy = hold_off ? 1'b0 : (bp_en ? (lf[0] | lf[3]) : 1'b1);
      if (!rst && stim_q.size() != 0 && in_rdy && (!bp_en || lf[5] | lf[7])) begin
        in_wr   = 1'b1;
        in_ctrl = stim_q[0].c;
        in_data = stim_q[0].d;
        void'(stim_q.pop_front());
      end else begin
        in_wr = 1'b0;
      end
    end
  end

  // Monitor: scoreboard comparison of every output word.
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && out_wr) begin
        if (exp_q.size() == 0) begin
          check("R6", {out_ctrl, out_data}, 72'hx);
        end else begin
          check(cur_req, {out_ctrl, out_data}, {exp_q[0].c, exp_q[0].d});
          void'(exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    // R9: reset state at the ports
    check("R9", {71'd0, in_rdy}, 72'd1);
    check("R9", {71'd0, out_wr}, 72'd0);
    // R9: zero key means passthrough
    cur_req = "R9"; add_packet(1, 8, 32'h0, 8'h11, 0); drain();

    key_write(32'hA5C3_0F96);
    cur_req = "R3"; add_packet(2, 9, 32'hA5C3_0F96, 8'h22, 0); drain();
    cur_req = "R1"; add_packet(3, 9, 32'hA5C3_0F96, 8'h33, 1); drain();
    cur_req = "R4"; add_packet(4, 6, 32'hA5C3_0F96, 8'h44, 0); drain();

    // R5: end of packet on the boundary word, inside the header, back to back
    cur_req = "R5";
    add_packet(1, 5, 32'hA5C3_0F96, 8'h55, 0);
    add_packet(1, 2, 32'hA5C3_0F96, 8'h56, 0);
    add_packet(2, 3, 32'hA5C3_0F96, 8'h57, 0);
    add_packet(1, 7, 32'hA5C3_0F96, 8'h58, 0);
    drain();

    key_write(32'hFFFF_FFFF);
    cur_req = "R2"; add_packet(1, 6, 32'hFFFF_FFFF, 8'h66, 0); drain();

    // R6: random backpressure and input gaps
    bp_en = 1; cur_req = "R6";
    add_packet(1, 12, 32'hFFFF_FFFF, 8'h71, 0);
    add_packet(2, 5, 32'hFFFF_FFFF, 8'h72, 0);
    add_packet(1, 9, 32'hFFFF_FFFF, 8'h73, 1);
    drain();

    // R8: key written mid-frame applies to the next frame only
    key_write(32'h1357_9BDF);
    cur_req = "R8";
    add_packet(1, 24, 32'h1357_9BDF, 8'h81, 0);
    while (exp_q.size() > 22) @(negedge clk);
    key_write(32'h2468_ACE0);
    add_packet(1, 10, 32'h2468_ACE0, 8'h82, 0);
    drain();
    bp_en = 0;

    // R7: stalled output fills the FIFO and drops in_rdy
    hold_off = 1; repeat (2) @(negedge clk);
    cur_req = "R7";
    add_packet(1, 6, 32'h2468_ACE0, 8'h91, 0);
    repeat (20) @(negedge clk);
    check("R7", {71'd0, in_rdy}, 72'd0);
    check("R7", 72'(stim_q.size()), 72'd3);
    check("R6", {71'd0, out_wr}, 72'd0);
    hold_off = 0;
    drain();
    check("R7", {71'd0, in_rdy}, 72'd1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule